// File: doc/BRIEF.md
# Segment-Insertion Scan Network with Per-Chain Scan Enables

This block is a reconfigurable scan network that sits behind a test access port. The port's state machine is not part of the block. It arrives as three strobes that are already decoded: shift, capture and update. A short gateway register comes first in the path and drives a configuration word for the die. A row of segment insertion bits follows it. Each insertion bit guards one instrument's data register. When an insertion bit's shadow is open, the guarded register is spliced into the serial path directly after that bit. Instruments can therefore be placed in the path together or one at a time.

One instrument is a scan-control register with one bit per internal scan chain. Each of its shadow bits is ANDed with the open state of its own insertion bit, and the result is a dedicated scan enable for that chain. Any subset of chains can be switched on at once. A test schedule can therefore lower parallelism to respect a power limit after bonding, or run chains in parallel before it.

Top module: `sib_scan_net`

## Requirements
- R1: After reset every shadow bit (gateway, insertion bits, instrument registers) is 0, `gw_cfg` and `chain_se` are 0, and the serial path is GW+N_INST stages long.
- R2: The path runs from `scan_in` through the gateway bits, then for each instrument k in increasing k its insertion bit, followed by its register (bit 0 nearest the insertion bit) when that insertion bit's shadow is 1. Its length is GW+N_INST plus the widths of the open registers: N_CHAIN for instrument SCI and DW for the others.
- R3: Each cycle with `shift_en` moves every path stage one place toward `scan_out`, and `scan_out` shows the last stage.
- R4: `update_en` copies the shift stages into the shadows of the gateway, of all insertion bits, and of every register whose insertion bit was open before the strobe. A closed register keeps its shadow.
- R5: `capture_en` loads every stage in the path with its own shadow value.
- R6: `chain_se[j]` is 1 exactly when bit j of the scan-control shadow is 1 and the scan-control instrument's insertion bit shadow is 1.
- R7: All 2^N_CHAIN patterns of the scan-control shadow reach `chain_se` unchanged while that instrument is open.
- R8: `gw_cfg` equals the gateway shadow, with gateway bit 0 being the stage nearest `scan_in`. It changes only on `update_en`.
- R9: When no strobe is asserted, all shadows and outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_in | input | 1 | Serial data into the gateway |
| shift_en | input | 1 | Shift strobe |
| capture_en | input | 1 | Capture strobe |
| update_en | input | 1 | Update strobe |
| scan_out | output | 1 | Serial data from the last path stage |
| gw_cfg | output | GW | Gateway shadow (configuration word) |
| chain_se | output | N_CHAIN | Per-chain scan enables |

## Verification
On every cycle, the assertions check the following. The scan enables and the gateway word never change without an update strobe. A closed scan-control register keeps its shadow. No chain enable is raised while its insertion bit is closed. The outputs leave reset clean. Only the bench's scenarios can show the serial behaviour. These scenarios cover the path length for every insertion-bit pattern and the order of bits seen at `scan_out` after a capture. They also cover every enable pattern reaching the chains, and a value written while the register was closed never arriving.

// File: rtl/sib_scan_net.sv
module sib_scan_net #(
  parameter int N_INST  = 3,
  parameter int N_CHAIN = 4,
  parameter int DW      = 3,
  parameter int GW      = 2,
  parameter int SCI     = N_INST - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scan_in,
  input  logic               shift_en,
  input  logic               capture_en,
  input  logic               update_en,
  output logic               scan_out,
  output logic [GW-1:0]      gw_cfg,
  output logic [N_CHAIN-1:0] chain_se
);

  logic [GW-1:0]      gw_s, gw_u;
  logic [N_INST:0]    link;
  logic [N_INST-1:0]  sib_upd;
  logic [N_CHAIN-1:0] ctl_upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gw_s <= '0;
      gw_u <= '0;
    end else if (capture_en) begin
      gw_s <= gw_u;
    end else if (shift_en) begin
      gw_s <= {gw_s[GW-2:0], scan_in};
    end else if (update_en) begin
      gw_u <= gw_s;
    end
  end

  assign link[0] = gw_s[GW-1];
  assign gw_cfg  = gw_u;

  for (genvar k = 0; k < N_INST; k++) begin : g_seg
    localparam int W = (k == SCI) ? N_CHAIN : DW;
    logic         sib_s, sib_u;
    logic [W-1:0] t_s, t_u;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sib_s <= 1'b0;
        sib_u <= 1'b0;
        t_s   <= '0;
        t_u   <= '0;
      end else if (capture_en) begin
        sib_s <= sib_u;
        if (sib_u) t_s <= t_u;
      end else if (shift_en) begin
        sib_s <= link[k];
        if (sib_u) t_s <= {t_s[W-2:0], sib_s};
      end else if (update_en) begin
        sib_u <= sib_s;
        if (sib_u) t_u <= t_s;
      end
    end

    assign link[k+1]  = sib_u ? t_s[W-1] : sib_s;
    assign sib_upd[k] = sib_u;

    if (k == SCI) begin : g_ctl
      assign ctl_upd = t_u;
    end
  end

  assign scan_out = link[N_INST];
  assign chain_se = ctl_upd & {N_CHAIN{sib_upd[SCI]}};

endmodule

// File: rtl/sib_scan_net_chk.sv
module sib_scan_net_chk #(
  parameter int N_INST  = 3,
  parameter int N_CHAIN = 4,
  parameter int GW      = 2,
  parameter int SCI     = N_INST - 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               update_en,
  input logic [GW-1:0]      gw_cfg,
  input logic [N_CHAIN-1:0] chain_se,
  input logic [N_INST-1:0]  sib_sh,
  input logic [N_CHAIN-1:0] ctl_sh
);

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (chain_se == '0 && gw_cfg == '0 && sib_sh == '0)); // R1

  AST_SE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(chain_se)); // R9

  AST_GW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(gw_cfg)); // R8

  AST_CTL_CLOSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sib_sh[SCI] |=> $stable(ctl_sh)); // R4

  AST_SE_NEEDS_SIB: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_se != '0) |-> sib_sh[SCI]); // R6

endmodule

bind sib_scan_net sib_scan_net_chk #(
  .N_INST(N_INST), .N_CHAIN(N_CHAIN), .GW(GW), .SCI(SCI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .update_en(update_en),
  .gw_cfg(gw_cfg), .chain_se(chain_se),
  .sib_sh(sib_upd), .ctl_sh(ctl_upd)
);

// File: tb/test_sib_scan_net.sv
`timescale 1ns/1ps
module test_sib_scan_net;
  localparam int N = 3, M = 4, DW = 3, GW = 2, SCI = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_in = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
  logic scan_out;
  logic [GW-1:0] gw_cfg;
  logic [M-1:0]  chain_se;

  always #10 clk = ~clk;

  sib_scan_net i_sib_scan_net (
    .clk(clk), .rst_n(rst_n), .scan_in(scan_in), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .scan_out(scan_out),
    .gw_cfg(gw_cfg), .chain_se(chain_se)
  );

  int checks = 0, fails = 0;
  logic [63:0] vec;
  int vlen;
  logic [2:0]  cur_p = '0;
  logic [GW-1:0] gw_m = '0;
  logic [11:0] dat_m = '0;

  function automatic int wid(int k);
    return (k == SCI) ? M : DW;
  endfunction

  function automatic int exp_len(logic [2:0] p);
    int l = GW + N;
    for (int k = 0; k < N; k++) if (p[k]) l += wid(k);
    return l;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(logic [2:0] pth, logic [GW-1:0] g, logic [2:0] sb, logic [11:0] d);
    int pos = 0;
    vec = '0;
    for (int i = 0; i < GW; i++) begin vec[pos] = g[i]; pos++; end
    for (int k = 0; k < N; k++) begin
      vec[pos] = sb[k]; pos++;
      if (pth[k]) for (int b = 0; b < wid(k); b++) begin vec[pos] = d[4*k+b]; pos++; end
    end
    vlen = pos;
  endtask

  task automatic shift1(logic b);
    scan_in = b; shift_en = 1'b1;
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic pulse_update();
    update_en = 1'b1;
    @(negedge clk);
    update_en = 1'b0;
  endtask

  task automatic write_cfg(logic [2:0] np, logic [GW-1:0] g, logic [11:0] d);
    build(cur_p, g, np, d);
    for (int s = 0; s < vlen; s++) shift1(vec[vlen-1-s]);
    pulse_update();
    gw_m = g;
    for (int k = 0; k < N; k++)
      if (cur_p[k]) for (int b = 0; b < wid(k); b++) dat_m[4*k+b] = d[4*k+b];
    cur_p = np;
  endtask

  task automatic check_len(string req);
    int n;
    for (int i = 0; i < 20; i++) shift1(1'b0);
    shift1(1'b1);
    n = 1;
    while (scan_out !== 1'b1 && n < 40) begin shift1(1'b0); n++; end
    chk(n == exp_len(cur_p), req, n, exp_len(cur_p));
  endtask

  task automatic readback(string req);
    logic [63:0] got = '0;
    capture_en = 1'b1;
    @(negedge clk);
    capture_en = 1'b0;
    build(cur_p, gw_m, cur_p, dat_m);
    for (int s = 0; s < vlen; s++) begin
      got[vlen-1-s] = scan_out;
      shift1(1'b0);
    end
    chk(got == vec, req, got, vec);
  endtask

  function automatic logic [M-1:0] exp_se();
    return cur_p[SCI] ? dat_m[4*SCI +: M] : '0;
  endfunction

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(chain_se == '0, "R1 se", chain_se, 0);
    chk(gw_cfg == '0, "R1 gw", gw_cfg, 0);
    check_len("R1 length");
    readback("R1 R5 reset shadows");

    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 16; c++) begin
        logic [11:0] d;
        logic [GW-1:0] g;
        g = GW'(p + c);
        d = {c[3:0], 1'b0, 3'(p*3 + c), 1'b0, 3'(p + 5*c)};
        write_cfg(p[2:0], g, d);
        write_cfg(p[2:0], g, d);
        chk(chain_se == exp_se(), "R6 R7 chain_se", chain_se, exp_se());
        chk(gw_cfg == gw_m, "R8 gw_cfg", gw_cfg, gw_m);
      end
      check_len("R2 path length");
      readback("R3 R5 capture order");
      repeat (5) @(negedge clk);
      chk(chain_se == exp_se(), "R9 hold se", chain_se, exp_se());
      chk(gw_cfg == gw_m, "R9 hold gw", gw_cfg, gw_m);
    end

    write_cfg(3'b100, 2'd1, 12'h500);
    write_cfg(3'b100, 2'd1, 12'h500);
    chk(chain_se == 4'h5, "R6 open", chain_se, 4'h5);
    write_cfg(3'b000, 2'd2, 12'hA00);
    chk(chain_se == 4'h0, "R6 closed", chain_se, 4'h0);
    write_cfg(3'b000, 2'd2, 12'h300);
    write_cfg(3'b100, 2'd3, 12'h600);
    chk(chain_se == 4'hA, "R4 closed register held", chain_se, 4'hA);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule